// File: doc/BRIEF.md
# Frame Timestamp Timer

This unit keeps a free-running bit-time counter for a serial bus controller and records when frames happen. Each qualified bit-tick pulse moves the counter forward by one while the controller is enabled. On a frame event, the counter value is copied into a timestamp register. A select input decides whether that event is the start of the frame or the end of the frame.

When the counter reaches its top value it normally wraps to zero. With the freeze option set, it stops at the top value instead and raises a sticky overflow flag. A clear command zeroes the counter, drops the flag and lets the counter run again.

Eight per-mailbox time marks are written through a small register port. In time-triggered mode, a one-cycle trigger pulse is raised for each mailbox whose mark the counter reaches. A combinational read port returns the marks, the counter, the timestamp and the status.

Top module: `frame_timestamp_timer`

## Requirements
- R1: After reset the counter, timestamp, overflow flag, trigger pulses and all time marks are zero.
- R2: The counter advances by exactly one at each clock edge where bitTick and ctrlEnable are both high. It keeps its value when either of them is low.
- R3: With freezeEnable low, a tick at 0xFFFF wraps the counter to 0 and leaves the overflow flag low.
- R4: With freezeEnable high, a tick at 0xFFFF holds the counter at 0xFFFF and sets the overflow flag. While the flag is set, further ticks are ignored, even if freezeEnable later drops.
- R5: clearCmd zeroes the counter and clears the overflow flag, which restarts a frozen counter. It wins over a tick in the same cycle.
- R6: With captureAtEnd = 0, a sofPulse copies the counter value into the timestamp. The value copied is the one present before that cycle's tick. An eofPulse has no effect.
- R7: With captureAtEnd = 1, an eofPulse copies the counter value into the timestamp, and a sofPulse has no effect.
- R8: Outside a selected frame event, the timestamp holds its last captured value.
- R9: A write with wrEn high stores wrData into the mark of mailbox wrIdx. The read port is combinational:
  - rdAddr 0 to 7 returns the marks.
  - rdAddr 8 returns the counter.
  - rdAddr 9 returns the timestamp.
  - rdAddr 10 returns the overflow flag in bit 0.
  - Any other address returns 0.
- R10: markHit[i] is high for one cycle, in the cycle the counter first shows a value equal to mark i. The counter must have taken that value through a tick or a clear, and ttModeEnable must have been high in that cycle. The mark compared is the one held before that edge. A counter held by freeze raises no pulse.
- R11: While ttModeEnable is low, no markHit pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlEnable | input | 1 | Controller enable; ticks count only while high |
| bitTick | input | 1 | One pulse per bit time |
| sofPulse | input | 1 | Start-of-frame event |
| eofPulse | input | 1 | End-of-frame event |
| captureAtEnd | input | 1 | 0: capture at start of frame, 1: capture at end of frame |
| freezeEnable | input | 1 | Stop at top value instead of wrapping |
| ttModeEnable | input | 1 | Time-triggered mode; enables mark comparison |
| clearCmd | input | 1 | Clear counter and overflow, restart a frozen counter |
| wrEn | input | 1 | Time-mark write strobe |
| wrIdx | input | 3 | Mailbox index of the mark written |
| wrData | input | 16 | Mark value written |
| rdAddr | input | 4 | Read select |
| rdData | output | 16 | Read data |
| timerValue | output | 16 | Current counter value |
| stampValue | output | 16 | Last captured timestamp |
| overflowFlag | output | 1 | Sticky freeze-at-top flag |
| markHit | output | 8 | Per-mailbox mark-reached pulses |

## Verification
The hardest states to reach are the two ends of the counter range. A wrap to zero, a freeze at 0xFFFF and a match against a mark of 0xFFFF only occur after 65535 accepted ticks.

The stimulus clears the counter and then ticks on every cycle for a full range, checking the wrap with freeze off. It then repeats the run with freeze on, to check the hold, the sticky flag and the refusal of later ticks. A mark of zero is checked through the clear path, since a tick can only reach zero again through a wrap.

// File: rtl/ts_timer_pkg.sv
package ts_timer_pkg;

  // Strobes from the control half to the datapath half, one cycle each.
  typedef struct packed {
    logic clearCnt;    // load zero into the counter
    logic stepCnt;     // add one to the counter
    logic latchStamp;  // copy the counter into the timestamp
    logic newValue;    // counter takes a fresh value at this edge
  } tsStrobe_t;

endpackage

// File: rtl/ts_timer_ctrl.sv
module ts_timer_ctrl
  import ts_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlEnable,
  input  logic      bitTick,
  input  logic      sofPulse,
  input  logic      eofPulse,
  input  logic      captureAtEnd,
  input  logic      freezeEnable,
  input  logic      clearCmd,
  input  logic      cntAtMax,
  output tsStrobe_t strobe,
  output logic      overflowFlag
);

  logic overflowQ;
  logic tickOk;
  logic freezeNow;
  logic stepNow;
  logic frameEvent;

  // A set overflow flag doubles as the frozen state.
  assign tickOk     = ctrlEnable & bitTick & ~overflowQ & ~clearCmd;
  assign freezeNow  = tickOk & cntAtMax & freezeEnable;
  assign stepNow    = tickOk & ~(cntAtMax & freezeEnable);
  assign frameEvent = captureAtEnd ? eofPulse : sofPulse;

  always_comb begin
    strobe            = '0;
    strobe.clearCnt   = clearCmd;
    strobe.stepCnt    = stepNow;
    strobe.latchStamp = frameEvent;
    strobe.newValue   = clearCmd | stepNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflowQ <= 1'b0;
    end else if (clearCmd) begin
      overflowQ <= 1'b0;
    end else if (freezeNow) begin
      overflowQ <= 1'b1;
    end
  end

  assign overflowFlag = overflowQ;

endmodule

// File: rtl/ts_mark_slot.sv
module ts_mark_slot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrHere,
  input  logic [CNT_W-1:0] wrData,
  input  logic             ttModeEnable,
  input  logic             newValue,
  input  logic [CNT_W-1:0] nextCount,
  output logic [CNT_W-1:0] markVal,
  output logic             hitPulse
);

  logic [CNT_W-1:0] markQ;
  logic             hitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markQ <= '0;
      hitQ  <= 1'b0;
    end else begin
      // Compare against the value the counter is about to show.
      hitQ <= ttModeEnable & newValue & (nextCount == markQ);
      if (wrHere) markQ <= wrData;
    end
  end

  assign markVal  = markQ;
  assign hitPulse = hitQ;

endmodule

// File: rtl/ts_timer_datapath.sv
module ts_timer_datapath
  import ts_timer_pkg::*;
#(
  parameter  int CNT_W     = 16,
  parameter  int NUM_MARKS = 8,
  localparam int IDX_W     = (NUM_MARKS > 1) ? $clog2(NUM_MARKS) : 1,
  localparam int ADDR_W    = $clog2(NUM_MARKS + 3)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tsStrobe_t            strobe,
  input  logic                 ttModeEnable,
  input  logic                 overflowFlag,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [CNT_W-1:0]     rdData,
  output logic [CNT_W-1:0]     countOut,
  output logic [CNT_W-1:0]     stampOut,
  output logic                 cntAtMax,
  output logic [NUM_MARKS-1:0] markHit
);

  localparam int CNT_ADDR  = NUM_MARKS;
  localparam int STMP_ADDR = NUM_MARKS + 1;
  localparam int STAT_ADDR = NUM_MARKS + 2;

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] stampQ;
  logic [CNT_W-1:0] nextCount;
  logic [CNT_W-1:0] markVals [NUM_MARKS];

  always_comb begin
    if (strobe.clearCnt)     nextCount = '0;
    else if (strobe.stepCnt) nextCount = countQ + CNT_W'(1);
    else                     nextCount = countQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      stampQ <= '0;
    end else begin
      countQ <= nextCount;
      if (strobe.latchStamp) stampQ <= countQ;
    end
  end

  for (genvar i = 0; i < NUM_MARKS; i++) begin : g_slot
    ts_mark_slot #(.CNT_W(CNT_W)) slot_i (
      .clk          (clk),
      .rstN         (rstN),
      .wrHere       (wrEn && (wrIdx == IDX_W'(i))),
      .wrData       (wrData),
      .ttModeEnable (ttModeEnable),
      .newValue     (strobe.newValue),
      .nextCount    (nextCount),
      .markVal      (markVals[i]),
      .hitPulse     (markHit[i])
    );
  end

  always_comb begin
    rdData = '0;
    if (rdAddr < ADDR_W'(NUM_MARKS)) begin
      rdData = markVals[rdAddr[IDX_W-1:0]];
    end else if (rdAddr == ADDR_W'(CNT_ADDR)) begin
      rdData = countQ;
    end else if (rdAddr == ADDR_W'(STMP_ADDR)) begin
      rdData = stampQ;
    end else if (rdAddr == ADDR_W'(STAT_ADDR)) begin
      rdData = {{(CNT_W-1){1'b0}}, overflowFlag};
    end
  end

  assign countOut = countQ;
  assign stampOut = stampQ;
  assign cntAtMax = &countQ;

endmodule

// File: rtl/frame_timestamp_timer.sv
module frame_timestamp_timer
  import ts_timer_pkg::*;
#(
  parameter  int CNT_W     = 16,
  parameter  int NUM_MARKS = 8,
  localparam int IDX_W     = (NUM_MARKS > 1) ? $clog2(NUM_MARKS) : 1,
  localparam int ADDR_W    = $clog2(NUM_MARKS + 3)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlEnable,
  input  logic                 bitTick,
  input  logic                 sofPulse,
  input  logic                 eofPulse,
  input  logic                 captureAtEnd,
  input  logic                 freezeEnable,
  input  logic                 ttModeEnable,
  input  logic                 clearCmd,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [CNT_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [CNT_W-1:0]     rdData,
  output logic [CNT_W-1:0]     timerValue,
  output logic [CNT_W-1:0]     stampValue,
  output logic                 overflowFlag,
  output logic [NUM_MARKS-1:0] markHit
);

  tsStrobe_t strobe;
  logic      cntAtMax;

  ts_timer_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlEnable   (ctrlEnable),
    .bitTick      (bitTick),
    .sofPulse     (sofPulse),
    .eofPulse     (eofPulse),
    .captureAtEnd (captureAtEnd),
    .freezeEnable (freezeEnable),
    .clearCmd     (clearCmd),
    .cntAtMax     (cntAtMax),
    .strobe       (strobe),
    .overflowFlag (overflowFlag)
  );

  ts_timer_datapath #(.CNT_W(CNT_W), .NUM_MARKS(NUM_MARKS)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ttModeEnable (ttModeEnable),
    .overflowFlag (overflowFlag),
    .wrEn         (wrEn),
    .wrIdx        (wrIdx),
    .wrData       (wrData),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .countOut     (timerValue),
    .stampOut     (stampValue),
    .cntAtMax     (cntAtMax),
    .markHit      (markHit)
  );

endmodule

// File: rtl/frame_timestamp_timer_chk.sv
module frame_timestamp_timer_chk #(
  parameter int CNT_W     = 16,
  parameter int NUM_MARKS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ctrlEnable,
  input logic                 bitTick,
  input logic                 sofPulse,
  input logic                 eofPulse,
  input logic                 captureAtEnd,
  input logic                 freezeEnable,
  input logic                 ttModeEnable,
  input logic                 clearCmd,
  input logic [CNT_W-1:0]     timerValue,
  input logic [CNT_W-1:0]     stampValue,
  input logic                 overflowFlag,
  input logic [NUM_MARKS-1:0] markHit
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (timerValue == '0) && !overflowFlag);

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEnable && bitTick && !clearCmd && !overflowFlag && timerValue != TOP)
      |=> timerValue == $past(timerValue) + CNT_W'(1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clearCmd && !(ctrlEnable && bitTick)) |=> $stable(timerValue));

  // R4
  freeze_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEnable && bitTick && !clearCmd && freezeEnable && timerValue == TOP)
      |=> (timerValue == TOP) && overflowFlag);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !clearCmd) |=> overflowFlag && (timerValue == TOP));

  // R11
  tt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ttModeEnable |=> markHit == '0);

  // R6
  stamp_sof_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!captureAtEnd && sofPulse) |=> stampValue == $past(timerValue));

  // R7
  stamp_eof_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captureAtEnd && eofPulse) |=> stampValue == $past(timerValue));

  // R8
  stamp_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(captureAtEnd ? eofPulse : sofPulse) |=> $stable(stampValue));

endmodule

bind frame_timestamp_timer frame_timestamp_timer_chk #(
  .CNT_W(CNT_W), .NUM_MARKS(NUM_MARKS)
) chk_i (.*);

// File: tb/frame_timestamp_timer_test.sv
module frame_timestamp_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlEnable = 0, bitTick = 0, sofPulse = 0, eofPulse = 0;
  logic        captureAtEnd = 0, freezeEnable = 0, ttModeEnable = 0, clearCmd = 0;
  logic        wrEn = 0;
  logic [2:0]  wrIdx = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData, timerValue, stampValue;
  logic        overflowFlag;
  logic [7:0]  markHit;

  always #5 clk = ~clk;

  frame_timestamp_timer uut (.*);

  typedef struct {
    logic [15:0] cnt;
    logic [15:0] stamp;
    logic [15:0] rd;
    logic        ovf;
    logic [7:0]  hit;
    string       tag;
  } expItem_t;

  expItem_t    pending[$];
  int          nChecks = 0;
  int          nFails  = 0;
  bit          reported = 0;

  // Reference state, built from the requirements.
  logic [15:0] mCnt = '0, mStamp = '0;
  logic        mOvf = 0;
  logic [15:0] mMark [8];

  task automatic compare(string tag, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] readModel(logic [3:0] a);
    if (a < 4'd8)   return mMark[a[2:0]];
    if (a == 4'd8)  return mCnt;
    if (a == 4'd9)  return mStamp;
    if (a == 4'd10) return {15'd0, mOvf};
    return 16'd0;
  endfunction

  // Driver: inputs are already set (at a falling edge); predict the next edge.
  task automatic cycle(string tag);
    expItem_t    e;
    logic        adv, stepNow, frzNow;
    logic [15:0] nCnt;
    adv     = ctrlEnable && bitTick && !mOvf && !clearCmd;
    frzNow  = adv && (mCnt == 16'hFFFF) && freezeEnable;
    stepNow = adv && !((mCnt == 16'hFFFF) && freezeEnable);
    nCnt    = clearCmd ? 16'd0 : (stepNow ? mCnt + 16'd1 : mCnt);
    for (int i = 0; i < 8; i++)
      e.hit[i] = ttModeEnable && (clearCmd || stepNow) && (nCnt == mMark[i]);
    if (captureAtEnd ? eofPulse : sofPulse) mStamp = mCnt;
    mOvf = clearCmd ? 1'b0 : (mOvf | frzNow);
    mCnt = nCnt;
    if (wrEn) mMark[wrIdx] = wrData;
    e.cnt   = mCnt;
    e.stamp = mStamp;
    e.ovf   = mOvf;
    e.rd    = readModel(rdAddr);
    e.tag   = tag;
    pending.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: sample a little after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (pending.size() > 0) begin
        expItem_t e;
        e = pending.pop_front();
        compare(e.tag, "timer", timerValue, e.cnt);
        compare(e.tag, "stamp", stampValue, e.stamp);
        compare(e.tag, "overflow", {15'd0, overflowFlag}, {15'd0, e.ovf});
        compare(e.tag, "markHit", {8'd0, markHit}, {8'd0, e.hit});
        compare(e.tag, "rdData", rdData, e.rd);
      end
    end
  end

  task automatic finishRun();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 8; i++) mMark[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    compare("R1", "timer", timerValue, 16'd0);
    compare("R1", "stamp", stampValue, 16'd0);
    compare("R1", "overflow", {15'd0, overflowFlag}, 16'd0);
    compare("R1", "markHit", {8'd0, markHit}, 16'd0);
    compare("R1", "mark0", rdData, 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: write marks, read them back
    wrEn = 1;
    for (int i = 0; i < 8; i++) begin
      wrIdx  = 3'(i);
      wrData = (i == 0) ? 16'd3 : (i == 1) ? 16'd10 : (i == 2) ? 16'd0 :
               (i == 3) ? 16'hFFFF : 16'(200 + i);
      rdAddr = 4'(i);
      cycle("R9");
    end
    wrEn = 0;
    for (int i = 0; i < 16; i++) begin
      rdAddr = 4'(i);
      cycle("R9");
    end

    // R2: ticks with gaps, and ticks while disabled
    rdAddr = 4'd8;
    ctrlEnable = 1;
    for (int k = 0; k < 6; k++) begin
      bitTick = (k % 2 == 0);
      cycle("R2");
    end
    ctrlEnable = 0; bitTick = 1;
    for (int k = 0; k < 3; k++) cycle("R2");
    bitTick = 0;

    // R11: marks reached with time-triggered mode off
    ctrlEnable = 1; clearCmd = 1; cycle("R11");
    clearCmd = 0; bitTick = 1;
    for (int k = 0; k < 12; k++) cycle("R11");
    bitTick = 0;

    // R10: clear hits mark 2 (zero), ticks hit marks 0 and 1
    ttModeEnable = 1; clearCmd = 1; cycle("R10");
    clearCmd = 0; bitTick = 1;
    for (int k = 0; k < 12; k++) cycle("R10");
    bitTick = 0;
    for (int k = 0; k < 2; k++) cycle("R10");

    // R6: start-of-frame capture, end-of-frame ignored
    rdAddr = 4'd9; captureAtEnd = 0;
    bitTick = 1; sofPulse = 1; cycle("R6");
    sofPulse = 0; eofPulse = 1; cycle("R6");
    eofPulse = 0;
    // R8: stamp holds
    for (int k = 0; k < 4; k++) cycle("R8");
    // R7: end-of-frame capture, start-of-frame ignored
    captureAtEnd = 1;
    sofPulse = 1; cycle("R7");
    sofPulse = 0; eofPulse = 1; cycle("R7");
    eofPulse = 0; bitTick = 0;
    for (int k = 0; k < 3; k++) cycle("R8");

    // R5: clear wins over a same-cycle tick
    bitTick = 1; clearCmd = 1; cycle("R5");
    clearCmd = 0; bitTick = 0; cycle("R5");

    // R3: full run to the top, then wrap with freeze off
    rdAddr = 4'd10; freezeEnable = 0; bitTick = 1;
    for (int k = 0; k < 65535; k++) cycle("R3");
    cycle("R3");
    bitTick = 0; cycle("R3");

    // R4: full run again with freeze on, hold and sticky flag
    freezeEnable = 1; bitTick = 1;
    for (int k = 0; k < 65535; k++) cycle("R4");
    for (int k = 0; k < 3; k++) cycle("R4");
    freezeEnable = 0;
    for (int k = 0; k < 3; k++) cycle("R4");
    // R5: clear restarts the frozen counter
    clearCmd = 1; cycle("R5");
    clearCmd = 0;
    for (int k = 0; k < 3; k++) cycle("R5");
    bitTick = 0; ttModeEnable = 0;
    cycle("R5");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule